// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block learns, per static load, the signed difference between the load's effective address and the value the load returns. Loads that walk regularly allocated structures, such as list nodes or node and string pairs placed next to each other, keep that difference constant even when the loaded values have no stride. When such a load misses in the long-latency cache while the core runs ahead speculatively, the block supplies a guessed load value so that dependent address calculations can go on.

The block has two sides. The training side takes the PC, effective address and data of each completed load. A difference whose magnitude exceeds a parameter bound is treated as a non-pointer load and dropped. Training updates a 16-entry, fully associative table on the next clock edge. Each entry holds a PC tag, the stored difference and a 2-bit confidence counter. The query side takes the PC and effective address of a missing load, together with the miss and runahead qualifiers. From one combinational lookup it returns a predicted value and a valid flag.

Top module: `avd_predictor`

## Requirements
- R1: After reset the table holds no entries, so no query produces a prediction until training has taken place.
- R2: The stored difference is trn_addr minus trn_data, taken modulo 2^ADDR_W. A prediction returns qry_addr minus the stored difference. This holds even when successive loaded values follow no stride.
- R3: pred_valid can be 1 only while qry_miss and qry_runahead are both 1. If either is 0, pred_valid is 0.
- R4: A prediction needs a tag match on qry_pc and a confidence counter equal to 3. A newly allocated entry starts at 0, so a new PC needs four trainings with the same difference before it predicts.
- R5: Training a resident PC with a different in-bound difference writes the new difference into that entry and sets its confidence to 0.
- R6: Training a resident PC with its stored difference raises confidence by one, and the counter saturates at 3. Further matching trainings keep the entry predicting.
- R7: The training difference is read as a signed value. If it lies outside the range -DELTA_BOUND to +DELTA_BOUND, the training is ignored: no entry is allocated or changed. A difference of exactly +DELTA_BOUND or -DELTA_BOUND is accepted.
- R8: A PC that is not in the table is allocated as follows. The lowest-index invalid entry is used first. If every entry is valid, the entry with the lowest confidence is replaced, and among entries of equal confidence the one with the lowest index is chosen.
- R9: Training takes effect at the rising clock edge that follows a cycle with trn_valid high. A query made in that same cycle sees the table as it was before the training.
- R10: pred_value is 0 whenever pred_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trn_valid | input | 1 | A completed load is offered for training |
| trn_pc | input | PC_W | PC of the completed load |
| trn_addr | input | ADDR_W | Effective address of the completed load |
| trn_data | input | ADDR_W | Value returned by the completed load |
| qry_miss | input | 1 | The queried load missed in the long-latency cache |
| qry_runahead | input | 1 | The core is in runahead mode |
| qry_pc | input | PC_W | PC of the queried load |
| qry_addr | input | ADDR_W | Effective address of the queried load |
| pred_valid | output | 1 | A confident prediction is offered |
| pred_value | output | ADDR_W | Predicted load value, 0 when not valid |

## Verification
The assertions check the following on every cycle:
- a prediction appears only with both qualifiers high, on a matched entry whose confidence is full;
- the value output is zero when no prediction is offered;
- a mismatching training reloads the difference and clears confidence;
- a saturated entry stays saturated on a matching training;
- an out-of-bound training leaves the table untouched.

The replacement order, the exact ±DELTA_BOUND edges, the one-edge delay between training and prediction, and the predicted values for chains with no value stride can only be shown by the bench's scenarios. The bench covers these with directed sequences and with random traffic compared against a reference model.

// File: rtl/avd_pkg.sv
package avd_pkg;

    // What one training beat does to the table
    typedef enum logic [2:0] {
        TR_IDLE,    // no training this cycle
        TR_SKIP,    // difference out of bound, dropped
        TR_BUMP,    // resident PC, same difference: raise confidence
        TR_RELOAD,  // resident PC, new difference: reload, clear confidence
        TR_ALLOC    // PC not resident: take the victim entry
    } train_op_e;

endpackage

// File: rtl/avd_delta_filter.sv
module avd_delta_filter #(
    parameter int ADDR_W      = 32,
    parameter int DELTA_BOUND = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] data,
    output logic [ADDR_W-1:0] delta,
    output logic              in_bound
);
    localparam logic signed [ADDR_W:0] LIM_POS = (ADDR_W+1)'(DELTA_BOUND);
    localparam logic signed [ADDR_W:0] LIM_NEG = -LIM_POS;

    logic signed [ADDR_W:0] delta_x;

    always_comb begin
        delta    = addr - data;
        delta_x  = $signed({delta[ADDR_W-1], delta});
        in_bound = (delta_x <= LIM_POS) && (delta_x >= LIM_NEG);
    end
endmodule

// File: rtl/avd_tag_match.sv
module avd_tag_match #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]           vld,
    input  logic [ENTRIES-1:0][PC_W-1:0] tag,
    input  logic [PC_W-1:0]              pc,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tag[g] == pc);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/avd_victim_pick.sv
module avd_victim_pick #(
    parameter int ENTRIES = 16,
    parameter int CONF_W  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][CONF_W-1:0] conf,
    output logic [IDX_W-1:0]               idx
);
    // Rank: invalid entries sort below every valid one, then by confidence
    logic [ENTRIES-1:0][CONF_W:0] rank;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        assign rank[g] = vld[g] ? ({1'b0, conf[g]} + 1'b1) : '0;
    end

    logic [CONF_W:0] best;

    always_comb begin
        best = rank[0];
        idx  = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (rank[i] < best) begin
                best = rank[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/avd_predictor.sv
module avd_predictor #(
    parameter int ENTRIES     = 16,
    parameter int PC_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int CONF_W      = 2,
    parameter int DELTA_BOUND = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trn_valid,
    input  logic [PC_W-1:0]   trn_pc,
    input  logic [ADDR_W-1:0] trn_addr,
    input  logic [ADDR_W-1:0] trn_data,
    input  logic              qry_miss,
    input  logic              qry_runahead,
    input  logic [PC_W-1:0]   qry_pc,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_value
);
    import avd_pkg::*;

    localparam int               IDX_W    = $clog2(ENTRIES);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][PC_W-1:0]   tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] dlt;
        logic [ENTRIES-1:0][CONF_W-1:0] cnf;
    } tbl_t;

    tbl_t st_d, st_q;

    // Views of the table for the bound checker
    logic [ENTRIES-1:0][ADDR_W-1:0] delta_q;
    logic [ENTRIES-1:0][CONF_W-1:0] conf_q;
    assign delta_q = st_q.dlt;
    assign conf_q  = st_q.cnf;

    // Training side
    logic [ADDR_W-1:0] trn_delta;
    logic              trn_inb;
    logic              trn_hit;
    logic [IDX_W-1:0]  trn_idx;
    logic [IDX_W-1:0]  vic_idx;
    train_op_e         trn_op;

    avd_delta_filter #(
        .ADDR_W     (ADDR_W),
        .DELTA_BOUND(DELTA_BOUND)
    ) u_filter (
        .addr    (trn_addr),
        .data    (trn_data),
        .delta   (trn_delta),
        .in_bound(trn_inb)
    );

    avd_tag_match #(
        .ENTRIES(ENTRIES),
        .PC_W   (PC_W)
    ) u_trn_match (
        .vld(st_q.vld),
        .tag(st_q.tag),
        .pc (trn_pc),
        .hit(trn_hit),
        .idx(trn_idx)
    );

    avd_victim_pick #(
        .ENTRIES(ENTRIES),
        .CONF_W (CONF_W)
    ) u_victim (
        .vld (st_q.vld),
        .conf(st_q.cnf),
        .idx (vic_idx)
    );

    // Query side
    logic             qry_hit;
    logic [IDX_W-1:0] qry_idx;

    avd_tag_match #(
        .ENTRIES(ENTRIES),
        .PC_W   (PC_W)
    ) u_qry_match (
        .vld(st_q.vld),
        .tag(st_q.tag),
        .pc (qry_pc),
        .hit(qry_hit),
        .idx(qry_idx)
    );

    // Classify the training beat
    always_comb begin
        if (!trn_valid)                          trn_op = TR_IDLE;
        else if (!trn_inb)                       trn_op = TR_SKIP;
        else if (!trn_hit)                       trn_op = TR_ALLOC;
        else if (st_q.dlt[trn_idx] == trn_delta) trn_op = TR_BUMP;
        else                                     trn_op = TR_RELOAD;
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        unique case (trn_op)
            TR_BUMP: begin
                if (st_q.cnf[trn_idx] != CONF_MAX)
                    st_d.cnf[trn_idx] = st_q.cnf[trn_idx] + 1'b1;
            end
            TR_RELOAD: begin
                st_d.dlt[trn_idx] = trn_delta;
                st_d.cnf[trn_idx] = '0;
            end
            TR_ALLOC: begin
                st_d.vld[vic_idx] = 1'b1;
                st_d.tag[vic_idx] = trn_pc;
                st_d.dlt[vic_idx] = trn_delta;
                st_d.cnf[vic_idx] = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Combinational prediction
    always_comb begin
        pred_valid = qry_miss && qry_runahead && qry_hit &&
                     (st_q.cnf[qry_idx] == CONF_MAX);
        pred_value = pred_valid ? (qry_addr - st_q.dlt[qry_idx]) : '0;
    end
endmodule

// File: rtl/avd_predictor_chk.sv
module avd_predictor_chk #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int CONF_W  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             trn_valid,
    input logic                             trn_inb,
    input logic                             trn_hit,
    input logic [IDX_W-1:0]                 trn_idx,
    input logic [ADDR_W-1:0]                trn_delta,
    input logic                             qry_miss,
    input logic                             qry_runahead,
    input logic                             qry_hit,
    input logic [IDX_W-1:0]                 qry_idx,
    input logic                             pred_valid,
    input logic [ADDR_W-1:0]                pred_value,
    input logic [ENTRIES-1:0][ADDR_W-1:0]   delta_q,
    input logic [ENTRIES-1:0][CONF_W-1:0]   conf_q
);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    // R3
    a_r3_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (qry_miss && qry_runahead));

    // R4
    a_r4_full_conf: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (qry_hit && conf_q[qry_idx] == CONF_MAX));

    // R10
    a_r10_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (pred_value == '0));

    // R5
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid && trn_inb && trn_hit && delta_q[trn_idx] != trn_delta)
        |=> (conf_q[$past(trn_idx)] == '0 && delta_q[$past(trn_idx)] == $past(trn_delta)));

    // R6
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid && trn_inb && trn_hit && delta_q[trn_idx] == trn_delta &&
         conf_q[trn_idx] == CONF_MAX)
        |=> (conf_q[$past(trn_idx)] == CONF_MAX));

    // R7
    a_r7_skip_out_of_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid && !trn_inb) |=> ($stable(conf_q) && $stable(delta_q)));
endmodule

bind avd_predictor avd_predictor_chk #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W),
    .CONF_W (CONF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trn_valid   (trn_valid),
    .trn_inb     (trn_inb),
    .trn_hit     (trn_hit),
    .trn_idx     (trn_idx),
    .trn_delta   (trn_delta),
    .qry_miss    (qry_miss),
    .qry_runahead(qry_runahead),
    .qry_hit     (qry_hit),
    .qry_idx     (qry_idx),
    .pred_valid  (pred_valid),
    .pred_value  (pred_value),
    .delta_q     (delta_q),
    .conf_q      (conf_q)
);

// File: tb/avd_predictor_tb_top.sv
module avd_predictor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int BOUND      = 4096;
    localparam int POOL       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trn_valid = 1'b0;
    logic [31:0] trn_pc = '0, trn_addr = '0, trn_data = '0;
    logic        qry_miss = 1'b0, qry_runahead = 1'b0;
    logic [31:0] qry_pc = '0, qry_addr = '0;
    logic        pred_valid;
    logic [31:0] pred_value;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    avd_predictor #(
        .ENTRIES(N), .PC_W(32), .ADDR_W(32), .CONF_W(2), .DELTA_BOUND(BOUND)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_addr(trn_addr), .trn_data(trn_data),
        .qry_miss(qry_miss), .qry_runahead(qry_runahead), .qry_pc(qry_pc), .qry_addr(qry_addr),
        .pred_valid(pred_valid), .pred_value(pred_value)
    );

    // ---------------- reference model ----------------
    logic        m_vld [N];
    logic [31:0] m_tag [N];
    logic [31:0] m_dlt [N];
    int          m_cnf [N];

    function automatic void m_clear();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_dlt[i] = '0; m_cnf[i] = 0;
        end
    endfunction

    function automatic int m_find(logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    function automatic void m_train(logic [31:0] pc, logic [31:0] a, logic [31:0] d);
        logic [31:0] dl;
        int k, v, best;
        dl = a - d;
        if ($signed(dl) > BOUND || $signed(dl) < -BOUND) return;
        k = m_find(pc);
        if (k >= 0) begin
            if (m_dlt[k] == dl) begin
                if (m_cnf[k] < 3) m_cnf[k]++;
            end else begin
                m_dlt[k] = dl; m_cnf[k] = 0;
            end
        end else begin
            v = 0; best = 99;
            for (int i = 0; i < N; i++) begin
                int r;
                r = m_vld[i] ? m_cnf[i] + 1 : 0;
                if (r < best) begin best = r; v = i; end
            end
            m_vld[v] = 1'b1; m_tag[v] = pc; m_dlt[v] = dl; m_cnf[v] = 0;
        end
    endfunction

    function automatic logic m_pv(logic ms, logic ra, logic [31:0] pc);
        int k;
        k = m_find(pc);
        return ms && ra && k >= 0 && m_cnf[k] == 3;
    endfunction

    function automatic logic [31:0] m_pval(logic ms, logic ra, logic [31:0] pc, logic [31:0] a);
        if (!m_pv(ms, ra, pc)) return '0;
        return a - m_dlt[m_find(pc)];
    endfunction

    // ---------------- helpers ----------------
    task automatic check(string req, logic ev, logic [31:0] eval);
        total++;
        if (pred_valid !== ev || pred_value !== eval) begin
            bad++;
            $display("FAIL %s: got valid=%0b value=%h expected valid=%0b value=%h",
                     req, pred_valid, pred_value, ev, eval);
        end
    endtask

    // Drives one cycle at the falling edge; outputs settle 1 time unit later
    task automatic cyc(logic tv, logic [31:0] tp, logic [31:0] ta, logic [31:0] td,
                       logic qm, logic qr, logic [31:0] qp, logic [31:0] qa);
        @(negedge clk);
        trn_valid = tv; trn_pc = tp; trn_addr = ta; trn_data = td;
        qry_miss = qm; qry_runahead = qr; qry_pc = qp; qry_addr = qa;
        #1;
    endtask

    task automatic train(logic [31:0] pc, logic [31:0] a, logic [31:0] d);
        cyc(1'b1, pc, a, d, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic train_n(int n, logic [31:0] pc, logic [31:0] dl);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            a = $urandom;
            train(pc, a, a - dl);
        end
    endtask

    task automatic probe(string req, logic [31:0] pc, logic [31:0] a, logic ev, logic [31:0] eval);
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b1, pc, a);
        check(req, ev, eval);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trn_valid = 1'b0; qry_miss = 1'b0; qry_runahead = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    localparam logic [31:0] PA = 32'h0040_1000, PB = 32'h0040_2000, PC = 32'h0040_3000;

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R1: empty table after reset
        for (int i = 0; i < 4; i++) probe("R1 empty after reset", PA + i*4, 32'h1000_0000, 1'b0, '0);

        // R4: three matching trainings are not enough
        train_n(3, PA, 32'h10);
        probe("R4 conf 2 no prediction", PA, 32'h2000_0000, 1'b0, '0);

        // R9: fourth training; same-cycle query still sees old state
        cyc(1'b1, PA, 32'h3000_0010, 32'h3000_0000, 1'b1, 1'b1, PA, 32'h5000_0000);
        check("R9 same-cycle query sees old table", 1'b0, '0);
        // R2 / R9: next cycle predicts addr - delta
        probe("R2 R9 prediction after edge", PA, 32'h5000_0000, 1'b1, 32'h4FFF_FFF0);

        // R3 / R10: qualifiers gate the prediction
        cyc(1'b0, '0, '0, '0, 1'b0, 1'b1, PA, 32'h5000_0000);
        check("R3 R10 no miss", 1'b0, '0);
        cyc(1'b0, '0, '0, '0, 1'b1, 1'b0, PA, 32'h5000_0000);
        check("R3 R10 not runahead", 1'b0, '0);

        // R2: node/string pairs, values with no stride but constant difference
        for (int i = 0; i < 5; i++) begin
            logic [31:0] a;
            a = $urandom;
            probe("R2 no value stride", PA, a, 1'b1, a - 32'h10);
        end

        // R7: out-of-bound training on a confident PC leaves it intact
        train(PA, 32'h9000_0000, 32'h1000_0000);
        train(PA, 32'h0000_0000, 32'h0000_1001);
        probe("R7 out of bound ignored", PA, 32'h7000_0000, 1'b1, 32'h6FFF_FFF0);

        // R7: exact +BOUND accepted, -(BOUND+1) rejected
        train_n(4, PB, 32'(BOUND));
        probe("R7 +bound accepted", PB, 32'h0001_0000, 1'b1, 32'h0001_0000 - 32'(BOUND));
        train_n(4, PC, -32'(BOUND + 1));
        probe("R7 -bound-1 rejected", PC, 32'h0001_0000, 1'b0, '0);
        train_n(4, PC, -32'(BOUND));
        probe("R7 -bound accepted", PC, 32'h0001_0000, 1'b1, 32'h0001_0000 + 32'(BOUND));

        // R5: mismatch reloads and clears confidence
        train_n(1, PA, 32'h20);
        probe("R5 mismatch clears confidence", PA, 32'h8000_0000, 1'b0, '0);
        train_n(2, PA, 32'h20);
        probe("R5 still below full", PA, 32'h8000_0000, 1'b0, '0);
        train_n(1, PA, 32'h20);
        probe("R5 new delta predicts", PA, 32'h8000_0000, 1'b1, 32'h7FFF_FFE0);

        // R6: saturation keeps the entry predicting
        train_n(5, PA, 32'h20);
        probe("R6 saturated", PA, 32'h8000_0100, 1'b1, 32'h8000_00E0);

        // R8: replacement order
        do_reset();
        for (int i = 0; i < N; i++) begin
            logic [31:0] p;
            p = 32'h0100_0000 + i*4;
            train_n((i == 5 || i == 9) ? 3 : 4, p, 32'(8 * (i + 1)));
        end
        train_n(4, 32'h0200_0000, 32'h40);  // takes slot of PC #5 (lowest conf, lowest index)
        probe("R8 newcomer resident", 32'h0200_0000, 32'h1000, 1'b1, 32'h0FC0);
        train_n(1, 32'h0100_0000 + 9*4, 32'(8 * 10));
        probe("R8 equal-conf higher index kept", 32'h0100_0000 + 9*4, 32'h1000, 1'b1, 32'h1000 - 32'd80);
        probe("R8 other entry kept", 32'h0100_0000, 32'h1000, 1'b1, 32'h0FF8);
        train_n(1, 32'h0100_0000 + 5*4, 32'(8 * 6));
        probe("R8 evicted PC restarts", 32'h0100_0000 + 5*4, 32'h1000, 1'b0, '0);

        // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        do_reset();
        m_clear();
        begin
            logic [31:0] base [POOL];
            for (int i = 0; i < POOL; i++) base[i] = 32'($urandom_range(0, 2*BOUND)) - 32'(BOUND);
            for (int c = 0; c < 4000; c++) begin
                logic        tv, qm, qr;
                logic [31:0] tp, ta, td, qp, qa, dl;
                int          r, pi, qi;
                pi = $urandom_range(0, POOL-1);
                qi = $urandom_range(0, POOL-1);
                tv = ($urandom_range(0, 3) != 0);
                tp = 32'h0800_0000 + pi*8;
                r  = $urandom_range(0, 19);
                dl = base[pi];
                if (r == 0) begin
                    base[pi] = 32'($urandom_range(0, 2*BOUND)) - 32'(BOUND);
                    dl = base[pi];
                end else if (r == 1) begin
                    dl = 32'(BOUND + 1 + $urandom_range(0, 100000));
                    if ($urandom_range(0, 1) == 1) dl = -dl;
                end
                ta = $urandom;
                td = ta - dl;
                qm = ($urandom_range(0, 3) != 0);
                qr = ($urandom_range(0, 3) != 0);
                qp = 32'h0800_0000 + qi*8;
                qa = $urandom;
                cyc(tv, tp, ta, td, qm, qr, qp, qa);
                check("R2-random model compare R3 R4 R8 R10",
                      m_pv(qm, qr, qp), m_pval(qm, qr, qp, qa));
                if (tv) m_train(tp, ta, td);
            end
        end

        @(negedge clk);
        trn_valid = 1'b0; qry_miss = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule